// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block collects up to eight external interrupt pins and converts them into latched, individually maskable interrupt requests. Each pin first passes a two-stage synchronizer; a per-pin detector then raises a pending flag according to the pin's programmed sense code, which selects falling edge, rising edge, both edges, low level or high level. A pending flag reaches the pin's output only when the pin is unmasked and its priority field is nonzero. All per-pin outputs are ORed into one combined request.

Software reaches the block through a small register port with a write strobe, a 3-bit register select and a 32-bit data word; reads are combinational. Pin numbering in the bit-per-pin registers runs from the most significant bit downward, and the multi-bit fields likewise place pin 0 at the top of the word. Pending flags are acknowledged by writing zero to their position, so one pin is acknowledged by writing the inverted bit mask. Masking uses two write-only registers, one that sets mask bits and one that clears them.

Top module: `extirq_ctrl`

## Requirements
- R1: With source width W (parameter SRC_W, 8 or 32), pin n owns bit W-1-n of the source, mask-set and mask-clear registers; at most eight pins exist in one instance, and per-pin outputs use bit n for pin n.
- R2: Sense codes select the trigger: 0 falling edge, 1 rising edge, 2 low level, 3 high level, 4 either edge; a qualifying pin change sets the pending flag on the third rising clock edge after the pin changes (two synchronizer stages plus the pending register).
- R3: Sense codes 5 to 15 never set a pending flag.
- R4: The sense register (select 0) is read/write; pin n's field has SENSE_W bits (2 or 4, default 4) starting at bit 32-(n+1)*SENSE_W.
- R5: The priority register (select 1) is read/write with a 4-bit field per pin, pin n at bits 31-4n down to 28-4n; a field of 0 blocks the pin's output while leaving its pending flag intact.
- R6: Writing the source register (select 2) clears each pending flag whose bit is written 0 and leaves flags written 1 unchanged; writing all zeros clears every flag; reading it returns the pending flags, other bits 0.
- R7: A clear takes effect in the cycle it is written even if the pin is still qualifying; in a level mode with the level still active the flag is set again one clock later.
- R8: A 1 written to the mask-set register (select 3) masks the pin and a 1 written to the mask-clear register (select 4) unmasks it; 0 bits change nothing and both registers read as 0.
- R9: The mode register (select 5) stores only bit 23, which reads back as written; all its other bits read 0.
- R10: irq_pin_o[n] is high exactly when pin n is pending, unmasked and has a nonzero priority; irq_o is the OR of irq_pin_o.
- R11: After reset every pin is masked, every priority field, sense field and pending flag is 0 and the mode bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for the selected register |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins, bit n is pin n |
| irq_pin_o | output | NUM_PINS | Per-pin interrupt requests, bit n is pin n |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: eight pins, 4-bit sense fields and an 8-bit source register. The 4-bit sense field makes the either-edge code and the invalid codes 5 to 15 writable, so every trigger mode and the rejection of unused codes are exercised, and the 8-bit source width puts pin 0 at bit 7 and pin 7 at bit 0, which exposes any reversal of the pin order. All eight pins let the end pins and a middle pin be driven with the others held idle.

// File: rtl/extirq_pkg.sv
// Shared constants for the external interrupt pin controller.
// Assumes a 3-bit register select and 4-bit sense codes inside the block.
package extirq_pkg;

    localparam logic [2:0] ADR_SENSE = 3'd0;
    localparam logic [2:0] ADR_PRIO  = 3'd1;
    localparam logic [2:0] ADR_SRC   = 3'd2;
    localparam logic [2:0] ADR_MSET  = 3'd3;
    localparam logic [2:0] ADR_MCLR  = 3'd4;
    localparam logic [2:0] ADR_MODE  = 3'd5;

    localparam logic [3:0] SNS_FALL = 4'd0;
    localparam logic [3:0] SNS_RISE = 4'd1;
    localparam logic [3:0] SNS_LOW  = 4'd2;
    localparam logic [3:0] SNS_HIGH = 4'd3;
    localparam logic [3:0] SNS_BOTH = 4'd4;

endpackage

// File: rtl/extirq_sync.sv
// Two-stage synchronizer for the asynchronous interrupt pins.
// Assumes each pin is a slowly changing level; no glitch filtering.
module extirq_sync #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] async_i,
    output logic [NUM_PINS-1:0] sync_o
);

    logic [NUM_PINS-1:0] meta_q;

    // Capture the pins in two back-to-back flip-flop stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_o <= '0;
        end else begin
            meta_q <= async_i;
            sync_o <= meta_q;
        end
    end

endmodule

// File: rtl/extirq_detect.sv
// Per-pin trigger detector: compares the synchronized level with its value
// one clock earlier and raises a one-cycle or level hit per the sense code.
// Assumes codes arrive zero-extended to 4 bits; unknown codes give no hit.
module extirq_detect
    import extirq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   level_i,
    input  logic [4*NUM_PINS-1:0] code_i,
    output logic [NUM_PINS-1:0]   hit_o
);

    logic [NUM_PINS-1:0] prev_q;

    // Remember last cycle's synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_i;
    end

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        logic rise, fall;
        assign rise = level_i[n] & ~prev_q[n];
        assign fall = ~level_i[n] & prev_q[n];

        // Select the trigger condition named by this pin's code.
        always_comb begin
            case (code_i[4*n +: 4])
                SNS_FALL: hit_o[n] = fall;
                SNS_RISE: hit_o[n] = rise;
                SNS_LOW:  hit_o[n] = ~level_i[n];
                SNS_HIGH: hit_o[n] = level_i[n];
                SNS_BOTH: hit_o[n] = rise | fall;
                default:  hit_o[n] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/extirq_regs.sv
// Register file, pending flags and output gating of the pin controller.
// Assumes one register access per cycle; reads are combinational and
// a source write's zero bits override a same-cycle detector hit.
module extirq_regs
    import extirq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int SRC_W    = 8,
    parameter int MODE_BIT = 23
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [2:0]            addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    input  logic [NUM_PINS-1:0]   hit_i,
    output logic [4*NUM_PINS-1:0] code_o,
    output logic [NUM_PINS-1:0]   irq_pin_o
);

    logic [31:0]         sense_q;
    logic [31:0]         prio_q;
    logic                mode_q;
    logic [NUM_PINS-1:0] pend_q;
    logic [NUM_PINS-1:0] mask_q;
    logic [SRC_W-1:0]    src_view;

    logic wr_sense, wr_prio, wr_src, wr_mset, wr_mclr, wr_mode;
    assign wr_sense = wr_en && addr == ADR_SENSE;
    assign wr_prio  = wr_en && addr == ADR_PRIO;
    assign wr_src   = wr_en && addr == ADR_SRC;
    assign wr_mset  = wr_en && addr == ADR_MSET;
    assign wr_mclr  = wr_en && addr == ADR_MCLR;
    assign wr_mode  = wr_en && addr == ADR_MODE;

    // Hold the read/write configuration words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            prio_q  <= '0;
            mode_q  <= 1'b0;
        end else begin
            if (wr_sense) sense_q <= wdata;
            if (wr_prio)  prio_q  <= wdata;
            if (wr_mode)  mode_q  <= wdata[MODE_BIT];
        end
    end

    // Extract each pin's sense field, zero-extended to four bits.
    always_comb begin
        code_o = '0;
        for (int n = 0; n < NUM_PINS; n++)
            code_o[4*n +: SENSE_W] = sense_q[32-(n+1)*SENSE_W +: SENSE_W];
    end

    // Present the pending flags in descending pin order.
    always_comb begin
        src_view = '0;
        for (int n = 0; n < NUM_PINS; n++)
            src_view[SRC_W-1-n] = pend_q[n];
    end

    // Return the selected register; write-only registers read as zero.
    always_comb begin
        rdata = '0;
        case (addr)
            ADR_SENSE: rdata = sense_q;
            ADR_PRIO:  rdata = prio_q;
            ADR_SRC:   rdata[SRC_W-1:0] = src_view;
            ADR_MODE:  rdata[MODE_BIT] = mode_q;
            default:   rdata = '0;
        endcase
    end

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        localparam int BIT  = SRC_W - 1 - n;
        localparam int PLSB = 28 - 4*n;
        logic prio_on;
        assign prio_on = prio_q[PLSB +: 4] != 4'd0;

        // Latch a detector hit; a zero written to the source bit wins.
        always_ff @(posedge clk) begin
            if (!rst_n)                       pend_q[n] <= 1'b0;
            else if (wr_src && !wdata[BIT])   pend_q[n] <= 1'b0;
            else if (hit_i[n])                pend_q[n] <= 1'b1;
        end

        // Update the mask bit from the set and clear registers.
        always_ff @(posedge clk) begin
            if (!rst_n)                       mask_q[n] <= 1'b1;
            else if (wr_mset && wdata[BIT])   mask_q[n] <= 1'b1;
            else if (wr_mclr && wdata[BIT])   mask_q[n] <= 1'b0;
        end

        assign irq_pin_o[n] = pend_q[n] & ~mask_q[n] & prio_on;

        AST_MASK_SET_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_mset && wdata[BIT]) |=> !irq_pin_o[n]); // R8
        AST_UNMASK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_mclr && wdata[BIT] && pend_q[n] && prio_on) |=> irq_pin_o[n]); // R10
        AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_src && !wdata[BIT]) |=> !pend_q[n]); // R6
        AST_PRIO_ZERO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_prio && wdata[PLSB +: 4] == 4'd0) |=> !irq_pin_o[n]); // R5
        AST_BAD_CODE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            (!pend_q[n] && code_o[4*n +: 4] > SNS_BOTH) |=> !pend_q[n]); // R3
    end

endmodule

// File: rtl/extirq_ctrl.sv
// External interrupt pin controller top: synchronizer, trigger detector and
// register/pending logic, plus the combined request output.
// Assumes NUM_PINS <= 8, SENSE_W of 2 or 4 and SRC_W of 8 or 32.
module extirq_ctrl #(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int SRC_W    = 8,
    parameter int MODE_BIT = 23
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] irq_pin_o,
    output logic                irq_o
);

    localparam int CODE_W = 4 * NUM_PINS;

    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] hit;
    logic [CODE_W-1:0]   code;

    extirq_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_i),
        .sync_o (pin_sync)
    );

    extirq_detect #(.NUM_PINS(NUM_PINS)) u_detect (
        .clk    (clk),
        .rst_n  (rst_n),
        .level_i(pin_sync),
        .code_i (code),
        .hit_o  (hit)
    );

    extirq_regs #(
        .NUM_PINS(NUM_PINS),
        .SENSE_W (SENSE_W),
        .SRC_W   (SRC_W),
        .MODE_BIT(MODE_BIT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .hit_i    (hit),
        .code_o   (code),
        .irq_pin_o(irq_pin_o)
    );

    assign irq_o = |irq_pin_o;

    AST_COMBINED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_pin_o == '0) |-> !irq_o); // R10

endmodule

// File: tb/extirq_ctrl_test.sv
module extirq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  pin_i = '0;
    logic [7:0]  irq_pin_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    extirq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .pin_i(pin_i), .irq_pin_o(irq_pin_o), .irq_o(irq_o)
    );

    // {code[3:0], start level, end level, expected pending} for pin 2
    localparam logic [6:0] VEC [13] = '{
        {4'd0, 1'b1, 1'b0, 1'b1}, {4'd0, 1'b0, 1'b1, 1'b0},
        {4'd1, 1'b0, 1'b1, 1'b1}, {4'd1, 1'b1, 1'b0, 1'b0},
        {4'd4, 1'b0, 1'b1, 1'b1}, {4'd4, 1'b1, 1'b0, 1'b1},
        {4'd2, 1'b0, 1'b0, 1'b1}, {4'd2, 1'b1, 1'b1, 1'b0},
        {4'd3, 1'b1, 1'b1, 1'b1}, {4'd3, 1'b0, 1'b0, 1'b0},
        {4'd7, 1'b0, 1'b1, 1'b0}, {4'd7, 1'b1, 1'b0, 1'b0},
        {4'd15, 1'b0, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R11 reset state
        rd(3'd2, v); chk("R11 source after reset", v, 32'h0);
        rd(3'd1, v); chk("R11 priority after reset", v, 32'h0);
        rd(3'd0, v); chk("R11 sense after reset", v, 32'h0);
        chk("R11 irq after reset", {31'd0, irq_o}, 32'd0);

        // pin 0 rising, still masked from reset
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd0, 32'h1000_0000);
        pin_i[0] = 1'b1;
        settle(4);
        rd(3'd2, v); chk("R1 pin0 at source bit 7", v, 32'h80);
        chk("R11 masked at reset", {24'd0, irq_pin_o}, 32'h0);

        wr(3'd4, 32'h80);
        chk("R10 unmasked pin0 output", {24'd0, irq_pin_o}, 32'h01);
        chk("R10 combined output", {31'd0, irq_o}, 32'd1);

        wr(3'd1, 32'h0FFF_FFFF);
        chk("R5 priority zero blocks", {24'd0, irq_pin_o}, 32'h0);
        rd(3'd2, v); chk("R5 pending kept", v, 32'h80);
        wr(3'd1, 32'hFFFF_FFFF);
        chk("R5 priority restored", {24'd0, irq_pin_o}, 32'h01);

        wr(3'd3, 32'h00);
        chk("R8 zero mask-set ignored", {24'd0, irq_pin_o}, 32'h01);
        wr(3'd3, 32'h80);
        chk("R8 mask-set masks", {24'd0, irq_pin_o}, 32'h0);
        rd(3'd3, v); chk("R8 mask-set reads zero", v, 32'h0);
        wr(3'd4, 32'h7F);
        chk("R8 zero mask-clear bit ignored", {24'd0, irq_pin_o}, 32'h0);
        rd(3'd4, v); chk("R8 mask-clear reads zero", v, 32'h0);
        wr(3'd4, 32'hFF);

        // R6 selective and full clear
        wr(3'd0, 32'h1100_0000);
        pin_i[1] = 1'b1;
        settle(4);
        rd(3'd2, v); chk("R6 two pending", v, 32'hC0);
        wr(3'd2, 32'hBF);
        rd(3'd2, v); chk("R6 inverted mask clears pin1 only", v, 32'h80);
        wr(3'd2, 32'h00);
        rd(3'd2, v); chk("R6 all-zero write clears all", v, 32'h0);
        chk("R6 no request after clear", {31'd0, irq_o}, 32'd0);

        // R4 and R9 readback
        wr(3'd0, 32'hA5C3_1234);
        rd(3'd0, v); chk("R4 sense readback", v, 32'hA5C3_1234);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, v); chk("R9 mode bit only", v, 32'h0080_0000);
        wr(3'd5, 32'h0);
        rd(3'd5, v); chk("R9 mode cleared", v, 32'h0);

        // R2 / R3 table on pin 2 (source bit 5)
        pin_i = '0;
        wr(3'd0, 32'h0);
        settle(4);
        for (int i = 0; i < 13; i++) begin
            logic [3:0] code;
            logic       lv0, lv1, ex;
            {code, lv0, lv1, ex} = VEC[i];
            pin_i[2] = lv0;
            wr(3'd0, {8'd0, code, 20'd0});
            settle(4);
            wr(3'd2, 32'h0);
            pin_i[2] = lv1;
            settle(5);
            rd(3'd2, v);
            chk(code > 4'd4 ? "R3 invalid code source" : "R2 trigger source",
                {31'd0, v[5]}, {31'd0, ex});
            chk(code > 4'd4 ? "R3 invalid code output" : "R2 trigger output",
                {31'd0, irq_pin_o[2]}, {31'd0, ex});
        end

        // R2 latency: rising edge on pin 2 sets on the third edge
        pin_i = '0;
        wr(3'd0, 32'h0010_0000);
        settle(4);
        wr(3'd2, 32'h0);
        pin_i[2] = 1'b1;
        settle(2);
        rd(3'd2, v); chk("R2 not yet after two edges", {31'd0, v[5]}, 32'd0);
        settle(1);
        rd(3'd2, v); chk("R2 set after three edges", {31'd0, v[5]}, 32'd1);

        // R7 level re-assert after clear
        pin_i = '0;
        wr(3'd0, 32'h0003_0000);
        pin_i[3] = 1'b1;
        settle(4);
        rd(3'd2, v); chk("R7 level pending", {31'd0, v[4]}, 32'd1);
        wr(3'd2, 32'h0);
        rd(3'd2, v); chk("R7 cleared in write cycle", {31'd0, v[4]}, 32'd0);
        settle(1);
        rd(3'd2, v); chk("R7 re-asserted next cycle", {31'd0, v[4]}, 32'd1);

        // R1 last pin at bit 0
        pin_i = '0;
        wr(3'd0, 32'h0000_0001);
        settle(4);
        wr(3'd2, 32'h0);
        pin_i[7] = 1'b1;
        settle(4);
        rd(3'd2, v); chk("R1 pin7 at source bit 0", v, 32'h01);
        chk("R1 pin7 output bit", {24'd0, irq_pin_o}, 32'h80);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule